// File: doc/BRIEF.md
# Two-Way Set-Associative Read Cache

This block is a small read-only cache placed between a processor's byte-load port and a slower backing memory. Memory is addressed by word, and one memory word is one byte of the load port. Every load address splits into a tag, a set index and a word offset. The two ways of the indexed set are searched in parallel. A load that hits returns its byte one cycle after it is accepted.

A load that misses stalls the processor port. The cache issues a single block request to memory and collects every word of the block as memory returns them. It installs the block in a victim way, and then returns the requested byte. The victim is an empty way if the set has one. Otherwise it is the way used least recently. Hit and miss totals are kept in two free-running counters.

Top module: `rd_cache_2way`

## Requirements
- R1: While reset is active and after it is released, `hit_count` and `miss_count` are zero, `cpu_ready` is 1, `cpu_valid` and `mem_req` are 0, and every line is invalid, so the first load to any block misses.
- R2: A load address splits as offset = bit 0, set index = bit 1 and tag = bits 4:2. The byte returned is the memory word at exactly that address.
- R3: A load accepted while `cpu_ready` is 1 hits when either way of the indexed set is valid and holds the address tag. It then raises `cpu_valid` with the data on the following cycle, and `cpu_ready` stays 1.
- R4: A miss raises `mem_req` for one cycle with `mem_addr` = address bits 4:1. The whole block is installed, so a later load to the other word of that block hits.
- R5: During a miss, `cpu_ready` is 0 from the cycle after acceptance until the fill completes. `cpu_valid` rises together with `cpu_ready`, carrying the requested byte.
- R6: On a miss, an invalid way of the set is filled before any valid way is replaced. Two blocks with different tags in one set therefore both remain resident.
- R7: When both ways are valid, the miss replaces the way that has gone longest without a hit or a fill.
- R8: `hit_count` rises by one for each hit and `miss_count` rises by one for each miss, including first-reference misses. The two never change in the same cycle.
- R9: Memory returns the block's words on consecutive `mem_valid` cycles, lowest offset first, and each word lands at its own offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Load request, taken when `cpu_ready` is 1 |
| cpu_addr | input | 5 | Load byte address |
| cpu_ready | output | 1 | Cache can accept a load |
| cpu_valid | output | 1 | One-cycle strobe marking `cpu_data` valid |
| cpu_data | output | 8 | Loaded byte |
| mem_req | output | 1 | One-cycle block read request |
| mem_addr | output | 4 | Block address of the request |
| mem_valid | input | 1 | Memory word strobe |
| mem_data | input | 8 | Memory word |
| hit_count | output | 16 | Total hits |
| miss_count | output | 16 | Total misses |

## Verification
The bench builds the cache with its default parameters: a 5-bit address, two sets, two-word blocks and 16-bit counters. Its memory model answers after a three-cycle delay. With only eight tags per set and two ways, random loads over the 32-byte space keep forcing cold misses, invalid-way fills and LRU evictions. Directed sequences pin down the order in which the fill words arrive and the exact victim chosen.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int WAYS = 2;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_FILL  = 2'd2
  } fill_st_t;
endpackage

// File: rtl/rc_tag_match.sv
module rc_tag_match #(
  parameter int TAG_W = 3,
  parameter int WAYS  = 2,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]            look_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  logic [WAYS-1:0] match;

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign match[w] = way_vld[w] && (way_tag[w] == look_tag);
    end
  endgenerate

  always_comb begin
    hit_way = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end

  assign hit = |match;
endmodule

// File: rtl/rc_victim.sv
module rc_victim #(
  parameter int SETS  = 2,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic             touch_way,
  input  logic [SET_W-1:0] look_set,
  input  logic [1:0]       look_vld,
  output logic             victim
);
  logic [SETS-1:0] lru_q, lru_d;

  always_comb begin
    lru_d = lru_q;
    if (touch_en) lru_d[touch_set] = ~touch_way;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru_q <= '0;
    else        lru_q <= lru_d;
  end

  always_comb begin
    if (!look_vld[0])      victim = 1'b0;
    else if (!look_vld[1]) victim = 1'b1;
    else                   victim = lru_q[look_set];
  end
endmodule

// File: rtl/rd_cache_2way.sv
module rd_cache_2way #(
  parameter int ADDR_W = 5,
  parameter int OFF_W  = 1,
  parameter int IDX_W  = 1,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic [ADDR_W-1:0]       cpu_addr,
  output logic                    cpu_ready,
  output logic                    cpu_valid,
  output logic [DATA_W-1:0]       cpu_data,
  output logic                    mem_req,
  output logic [ADDR_W-OFF_W-1:0] mem_addr,
  input  logic                    mem_valid,
  input  logic [DATA_W-1:0]       mem_data,
  output logic [CNT_W-1:0]        hit_count,
  output logic [CNT_W-1:0]        miss_count
);
  import rc_pkg::*;

  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int SETS  = 1 << IDX_W;
  localparam int WORDS = 1 << OFF_W;
  localparam int BLK_W = ADDR_W - OFF_W;

  logic [SETS-1:0][WAYS-1:0]                   vld_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]        tag_q;
  logic [SETS-1:0][WAYS-1:0][WORDS-1:0][DATA_W-1:0] dat_q;

  fill_st_t st_q, st_d;
  logic [ADDR_W-1:0] pend_q, pend_d;
  logic              vway_q, vway_d;
  logic [OFF_W-1:0]  beat_q, beat_d;
  logic              rvld_q, rvld_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic [CNT_W-1:0]  hcnt_q, hcnt_d, mcnt_q, mcnt_d;

  logic [OFF_W-1:0] a_off;
  logic [IDX_W-1:0] a_idx;
  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] p_idx;
  logic [TAG_W-1:0] p_tag;
  logic [OFF_W-1:0] p_off;

  assign a_off = cpu_addr[OFF_W-1:0];
  assign a_idx = cpu_addr[OFF_W +: IDX_W];
  assign a_tag = cpu_addr[ADDR_W-1 -: TAG_W];
  assign p_off = pend_q[OFF_W-1:0];
  assign p_idx = pend_q[OFF_W +: IDX_W];
  assign p_tag = pend_q[ADDR_W-1 -: TAG_W];

  logic look_hit, look_way, victim;

  rc_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .way_vld  (vld_q[a_idx]),
    .way_tag  (tag_q[a_idx]),
    .look_tag (a_tag),
    .hit      (look_hit),
    .hit_way  (look_way)
  );

  logic accept, hit_acc, miss_acc, fill_wr, fill_last;

  assign accept    = (st_q == ST_IDLE) && cpu_req;
  assign hit_acc   = accept && look_hit;
  assign miss_acc  = accept && !look_hit;
  assign fill_wr   = (st_q == ST_FILL) && mem_valid;
  assign fill_last = fill_wr && (beat_q == OFF_W'(WORDS - 1));

  logic             touch_en;
  logic [IDX_W-1:0] touch_set;
  logic             touch_way;

  assign touch_en  = hit_acc || fill_last;
  assign touch_set = fill_last ? p_idx : a_idx;
  assign touch_way = fill_last ? vway_q : look_way;

  rc_victim #(.SETS(SETS)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (touch_en),
    .touch_set (touch_set),
    .touch_way (touch_way),
    .look_set  (a_idx),
    .look_vld  (vld_q[a_idx]),
    .victim    (victim)
  );

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    vway_d = vway_q;
    beat_d = beat_q;
    rvld_d = 1'b0;
    rdat_d = rdat_q;
    hcnt_d = hcnt_q;
    mcnt_d = mcnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (hit_acc) begin
          rvld_d = 1'b1;
          rdat_d = dat_q[a_idx][look_way][a_off];
          hcnt_d = hcnt_q + 1'b1;
        end else if (miss_acc) begin
          pend_d = cpu_addr;
          vway_d = victim;
          beat_d = '0;
          mcnt_d = mcnt_q + 1'b1;
          st_d   = ST_ISSUE;
        end
      end
      ST_ISSUE: st_d = ST_FILL;
      ST_FILL: begin
        if (fill_wr) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == p_off) rdat_d = mem_data;
          if (fill_last) begin
            rvld_d = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= '0;
      vway_q <= 1'b0;
      beat_q <= '0;
      rvld_q <= 1'b0;
      rdat_q <= '0;
      hcnt_q <= '0;
      mcnt_q <= '0;
      vld_q  <= '0;
      tag_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      vway_q <= vway_d;
      beat_q <= beat_d;
      rvld_q <= rvld_d;
      rdat_q <= rdat_d;
      hcnt_q <= hcnt_d;
      mcnt_q <= mcnt_d;
      if (fill_last) begin
        vld_q[p_idx][vway_q] <= 1'b1;
        tag_q[p_idx][vway_q] <= p_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fill_wr) dat_q[p_idx][vway_q][beat_q] <= mem_data;
  end

  assign cpu_ready  = (st_q == ST_IDLE);
  assign cpu_valid  = rvld_q;
  assign cpu_data   = rdat_q;
  assign mem_req    = (st_q == ST_ISSUE);
  assign mem_addr   = pend_q[ADDR_W-1:OFF_W];
  assign hit_count  = hcnt_q;
  assign miss_count = mcnt_q;

  logic [BLK_W-1:0] unused_blk;
  assign unused_blk = '0;
endmodule

// File: rtl/rc_checker.sv
module rc_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ready,
  input logic             cpu_valid,
  input logic             mem_req,
  input logic [CNT_W-1:0] hit_count,
  input logic [CNT_W-1:0] miss_count
);
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  stall_in_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !cpu_ready);

  // R5
  valid_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> cpu_ready);

  // R4
  miss_issues_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> mem_req);

  // R8
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + 1'b1));

  // R8
  cnt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !((hit_count != $past(hit_count)) && (miss_count != $past(miss_count))));
endmodule

bind rd_cache_2way rc_checker #(.CNT_W(CNT_W)) u_rc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_ready  (cpu_ready),
  .cpu_valid  (cpu_valid),
  .mem_req    (mem_req),
  .hit_count  (hit_count),
  .miss_count (miss_count)
);

// File: tb/tb_rd_cache_2way.sv
module tb_rd_cache_2way;
  localparam int MEM_LAT = 3;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_req;
  logic [4:0] cpu_addr;
  logic       cpu_ready, cpu_valid;
  logic [7:0] cpu_data;
  logic       mem_req;
  logic [3:0] mem_addr;
  logic       mem_valid;
  logic [7:0] mem_data;
  logic [15:0] hit_count, miss_count;

  int checks = 0;
  int fails  = 0;
  int m_hits = 0;
  int m_miss = 0;

  bit       r_vld [2][2];
  bit [2:0] r_tag [2][2];
  bit       r_lru [2];

  always #10 clk = ~clk;

  rd_cache_2way dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_valid(cpu_valid), .cpu_data(cpu_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  function automatic logic [7:0] mem_byte(input logic [4:0] a);
    return 8'(a * 29 + 7);
  endfunction

  // Reference model of the lookup and replacement rules
  function automatic bit model_access(input logic [4:0] a);
    bit s = a[1];
    bit [2:0] t = a[4:2];
    bit w;
    for (int i = 0; i < 2; i++) begin
      if (r_vld[s][i] && r_tag[s][i] == t) begin
        r_lru[s] = ~i[0];
        return 1'b1;
      end
    end
    if (!r_vld[s][0]) w = 1'b0;
    else if (!r_vld[s][1]) w = 1'b1;
    else w = r_lru[s];
    r_vld[s][w] = 1'b1;
    r_tag[s][w] = t;
    r_lru[s] = ~w;
    return 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Memory model: words of the block on consecutive cycles, low offset first
  initial begin
    mem_valid = 1'b0;
    mem_data  = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        automatic logic [3:0] blk = mem_addr;
        repeat (MEM_LAT) @(negedge clk);
        mem_valid = 1'b1;
        mem_data  = mem_byte({blk, 1'b0});
        @(negedge clk);
        mem_data  = mem_byte({blk, 1'b1});
        @(negedge clk);
        mem_valid = 1'b0;
      end
    end
  end

  task automatic do_load(input logic [4:0] a, input string tag, output bit was_hit);
    int  cyc = 0;
    bit  low = 0;
    bit  exp_hit;
    exp_hit = model_access(a);
    if (exp_hit) m_hits++; else m_miss++;
    check(cpu_ready == 1'b1, "R5 ready before load", int'(cpu_ready), 1);
    cpu_req  = 1'b1;
    cpu_addr = a;
    do begin
      @(negedge clk);
      cpu_req = 1'b0;
      cyc++;
      if (!cpu_ready) low = 1;
    end while (!cpu_valid && cyc < 100);
    was_hit = (cyc == 1);
    check(was_hit == exp_hit, {tag, " R3 hit/miss outcome"}, int'(was_hit), int'(exp_hit));
    check(cpu_data == mem_byte(a), {tag, " R2 load data"}, int'(cpu_data), int'(mem_byte(a)));
    if (!exp_hit)
      check(low && cpu_ready, {tag, " R5 stall then ready with data"}, int'(low), 1);
    check(hit_count == 16'(m_hits) && miss_count == 16'(m_miss), {tag, " R8 counters"},
          int'(hit_count) * 1000 + int'(miss_count), m_hits * 1000 + m_miss);
    @(negedge clk);
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit h;
    void'($urandom(32'd4711));
    for (int s = 0; s < 2; s++) begin
      r_lru[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        r_vld[s][w] = 1'b0;
        r_tag[s][w] = '0;
      end
    end
    rst_n = 1'b0; cpu_req = 1'b0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    check(hit_count == 0 && miss_count == 0, "R1 counters in reset", int'(hit_count) + int'(miss_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_ready && !cpu_valid && !mem_req, "R1 idle outputs", int'({cpu_ready, cpu_valid, mem_req}), 4);

    // Cold miss on odd word: second beat must land at offset 1
    do_load({3'd0, 1'b0, 1'b1}, "R1 cold", h);
    check(h == 0, "R1 cold miss", int'(h), 0);
    check(cpu_data == mem_byte(5'd1), "R9 beat order", int'(cpu_data), int'(mem_byte(5'd1)));
    do_load({3'd0, 1'b0, 1'b0}, "R4", h);
    check(h == 1, "R4 other word of block hits", int'(h), 1);
    do_load({3'd1, 1'b0, 1'b0}, "R6", h);
    check(h == 0, "R6 second tag misses", int'(h), 0);
    do_load({3'd0, 1'b0, 1'b1}, "R6", h);
    check(h == 1, "R6 first tag kept", int'(h), 1);
    do_load({3'd1, 1'b0, 1'b1}, "R6", h);
    check(h == 1, "R6 second tag kept", int'(h), 1);
    do_load({3'd0, 1'b0, 1'b0}, "R7", h);
    do_load({3'd2, 1'b0, 1'b1}, "R7", h);
    check(h == 0, "R7 new tag misses", int'(h), 0);
    do_load({3'd0, 1'b0, 1'b0}, "R7", h);
    check(h == 1, "R7 recently used way kept", int'(h), 1);
    do_load({3'd1, 1'b0, 1'b0}, "R7", h);
    check(h == 0, "R7 least recent way evicted", int'(h), 0);
    do_load({3'd0, 1'b1, 1'b0}, "R2 set1", h);
    check(h == 0, "R2 other set independent", int'(h), 0);

    for (int n = 0; n < 400; n++) begin
      automatic logic [4:0] a = 5'($urandom_range(0, 31));
      do_load(a, "rand", h);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule